// File: doc/BRIEF.md
# Row-Address Bloom Filter Bin

This block records whether a DRAM row address belongs to one retention bin. It holds a bit array and a set of independent hash units. Writing a row address sets one array bit per hash unit. Looking up a row address reports a hit only when every bit that the hash units select is set. A row that was written is therefore always found. A row that was never written may also be reported as a hit when other rows have set all of its bits, and a refresh scheduler accepts that outcome. The array cannot overflow: more writes only set more bits, and the array never runs out of room.

One parameter set serves a short-retention bin, for example 2048 bits with ten hash units, and another serves a longer-retention bin, for example 8192 bits with six hash units. A clear command empties the whole array one word per cycle. While the clear runs, the block raises a busy flag and ignores writes and lookups.

Top module: `bloom_bin`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), busy and resp_valid are 0, and every row address gives a miss when looked up.
- R2: Hash unit k, for k from 0 to NHASH-1, works in four steps. It rotates the ADDR_W-bit row left by (k mod ADDR_W). It XORs the result with the low ADDR_W bits of the 32-bit product (k+1)*0x9E3779B1. It zero-extends that value to a multiple of IDX_W = log2(BITS) bits. The XOR of all IDX_W-bit slices is the bit index.
- R3: An accepted insert (ins_valid high, busy low, clr_start low) sets the array bit at every index of the row. A later lookup of that row reports a hit, so the block gives no false negatives.
- R4: An accepted lookup (qry_valid high, busy low, clr_start low) sets resp_valid high one cycle later. In that cycle resp_hit is 1 exactly when all NHASH indexed bits were set. This can include rows that were never inserted. With no accepted lookup, resp_valid is 0.
- R5: When an insert and a lookup are accepted in the same cycle, the lookup response reflects the array before that insert.
- R6: A clr_start seen while busy is low starts a clear. busy stays high for exactly BITS/WORD_W cycles, one word being zeroed per cycle. Once busy falls, every lookup misses.
- R7: Inserts and lookups presented while busy is high, or in the cycle clr_start is accepted, have no effect. They produce no response and set no bits.
- R8: A clr_start seen while busy is high is ignored. The running clear ends at its original time.
- R9: The array never overflows. After every possible row has been inserted, every lookup hits and the block still accepts a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_start | input | 1 | Request to empty the array |
| ins_valid | input | 1 | Insert request |
| ins_row | input | ADDR_W | Row address to insert |
| qry_valid | input | 1 | Lookup request |
| qry_row | input | ADDR_W | Row address to look up |
| busy | output | 1 | Clear in progress; requests ignored |
| resp_valid | output | 1 | Lookup result present this cycle |
| resp_hit | output | 1 | Lookup result: 1 = possibly present |

## Verification
The assertions assume that rst_n is held low for at least one edge before any request. They also assume the requester may raise clr_start, ins_valid and qry_valid freely, including while busy is high, since the block is required to drop such requests. The bench runs a small configuration: 8-bit rows, 64 bits, three hashes and 8-bit words. Every one of the 256 rows is looked up after each phase, and each result is compared with a bit model built from the hash definition. Requests are driven during busy and during the clr_start cycle on purpose, so the blocking rules are exercised, while resets only occur with inputs idle.

// File: rtl/bloom_pkg.sv
// Shared constants and helpers for the row-address Bloom filter bin.
// Assumes array sizes are powers of two no wider than 2^30 bits.
package bloom_pkg;

    // Odd multiplier used to derive a distinct constant per hash unit.
    localparam logic [31:0] HASH_MIX = 32'h9E3779B1;

    // Width of a counter able to hold values 0..n-1 (at least one bit).
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bloom_hash.sv
// One hash unit: rotates the row address, XORs a per-unit constant and
// folds the result down to an array index. Purely combinational.
// Assumes ADDR_W <= 32 and K < NHASH.
module bloom_hash #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 11,
    parameter int K      = 0
) (
    input  logic [ADDR_W-1:0] row,
    output logic [IDX_W-1:0]  idx
);
    import bloom_pkg::*;

    localparam int ROT   = K % ADDR_W;
    localparam int FOLDS = (ADDR_W + IDX_W - 1) / IDX_W;
    localparam int PW    = FOLDS * IDX_W;
    localparam logic [31:0] PROD = 32'(K + 1) * HASH_MIX;
    localparam logic [ADDR_W-1:0] SALT = PROD[ADDR_W-1:0];

    logic [2*ADDR_W-1:0] dbl;
    logic [ADDR_W-1:0]   mixed;
    logic [PW-1:0]       pad;

    // Rotate left by ROT and apply the per-unit salt.
    assign dbl   = {row, row};
    assign mixed = dbl[ADDR_W-ROT +: ADDR_W] ^ SALT;
    assign pad   = PW'(mixed);

    // XOR all IDX_W-bit slices together into the index.
    always_comb begin
        idx = '0;
        for (int f = 0; f < FOLDS; f++) begin
            idx = idx ^ pad[f*IDX_W +: IDX_W];
        end
    end

endmodule

// File: rtl/bloom_array.sv
// Bit array with NHASH parallel set ports, NHASH parallel read ports and
// a one-word clear port. Clear and set never coincide (the top blocks
// sets during a clear).
module bloom_array #(
    parameter int BITS   = 2048,
    parameter int WORD_W = 64,
    parameter int NHASH  = 10,
    parameter int IDX_W  = 11,
    parameter int CW     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_en,
    input  logic [NHASH-1:0][IDX_W-1:0] set_idx,
    input  logic [NHASH-1:0][IDX_W-1:0] rd_idx,
    input  logic                        clr_en,
    input  logic [CW-1:0]               clr_word,
    output logic [NHASH-1:0]            rd_bits,
    output logic [BITS-1:0]             bits_o
);
    logic [BITS-1:0] bits_q;

    // Storage update: reset empties, clear zeroes a word, set marks bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            if (clr_en) begin
                bits_q[int'(clr_word)*WORD_W +: WORD_W] <= '0;
            end
            if (set_en) begin
                for (int k = 0; k < NHASH; k++) begin
                    bits_q[set_idx[k]] <= 1'b1;
                end
            end
        end
    end

    // Parallel read of every hashed position.
    always_comb begin
        for (int k = 0; k < NHASH; k++) begin
            rd_bits[k] = bits_q[rd_idx[k]];
        end
    end

    assign bits_o = bits_q;

endmodule

// File: rtl/bloom_clear_seq.sv
// Clear sequencer: once started, steps a word counter through NWORDS
// words, one per cycle, holding busy high meanwhile. Start is ignored
// while busy.
module bloom_clear_seq #(
    parameter int NWORDS = 32,
    parameter int CW     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic [CW-1:0] word
);
    localparam logic [CW-1:0] LAST = CW'(NWORDS - 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    // Sequencer state: idle -> sweeping words -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;
    assign word = cnt_q;

    // R6: the sweep continues until the last word, then stops.
    p_sweep_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != LAST) |=> busy_q);
    p_sweep_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q == LAST) |=> !busy_q);
    // R8: busy only rises on a start seen while idle.
    p_no_self_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start) |=> !busy_q);

endmodule

// File: rtl/bloom_bin.sv
// Row-address Bloom filter bin: insert sets NHASH hashed bits, lookup
// reports the AND of those bits one cycle later, clear empties the array
// word by word. Assumes BITS is a power of two and a multiple of WORD_W.
module bloom_bin #(
    parameter int ADDR_W = 16,
    parameter int BITS   = 2048,
    parameter int NHASH  = 10,
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_start,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_row,
    input  logic              qry_valid,
    input  logic [ADDR_W-1:0] qry_row,
    output logic              busy,
    output logic              resp_valid,
    output logic              resp_hit
);
    import bloom_pkg::*;

    localparam int IDX_W  = $clog2(BITS);
    localparam int NWORDS = BITS / WORD_W;
    localparam int CW     = cnt_width(NWORDS);

    logic [NHASH-1:0][IDX_W-1:0] ins_idx;
    logic [NHASH-1:0][IDX_W-1:0] qry_idx;
    logic [NHASH-1:0]            rd_bits;
    logic [BITS-1:0]             all_bits;
    logic [CW-1:0]               clr_word;
    logic                        accept;
    logic                        ins_fire;
    logic                        qry_fire;
    logic                        resp_valid_q;
    logic                        resp_hit_q;

    // Hash units, one pair (insert side, lookup side) per hash function.
    for (genvar k = 0; k < NHASH; k++) begin : g_hash
        bloom_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .K(k)) u_ins_hash (
            .row (ins_row),
            .idx (ins_idx[k])
        );
        bloom_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .K(k)) u_qry_hash (
            .row (qry_row),
            .idx (qry_idx[k])
        );
    end

    bloom_clear_seq #(.NWORDS(NWORDS), .CW(CW)) u_clear (
        .clk   (clk),
        .rst_n (rst_n),
        .start (clr_start),
        .busy  (busy),
        .word  (clr_word)
    );

    // Requests pass only when no clear is running or being started.
    assign accept   = !busy && !clr_start;
    assign ins_fire = ins_valid && accept;
    assign qry_fire = qry_valid && accept;

    bloom_array #(
        .BITS(BITS), .WORD_W(WORD_W), .NHASH(NHASH), .IDX_W(IDX_W), .CW(CW)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (ins_fire),
        .set_idx  (ins_idx),
        .rd_idx   (qry_idx),
        .clr_en   (busy),
        .clr_word (clr_word),
        .rd_bits  (rd_bits),
        .bits_o   (all_bits)
    );

    // Lookup result register, sampling the array before same-edge inserts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_q <= 1'b0;
            resp_hit_q   <= 1'b0;
        end else begin
            resp_valid_q <= qry_fire;
            resp_hit_q   <= qry_fire && (&rd_bits);
        end
    end

    assign resp_valid = resp_valid_q;
    assign resp_hit   = resp_hit_q;

    // R3: every hashed bit of an accepted insert is set on the next cycle.
    for (genvar k = 0; k < NHASH; k++) begin : g_chk
        p_insert_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ins_fire |=> all_bits[$past(ins_idx[k])]);
    end
    // R7: a response only follows a lookup presented while not busy.
    p_resp_needs_query_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($past(qry_valid) && !$past(busy)));
    // R4: a hit is never reported without a valid response.
    p_hit_qualified_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> resp_valid);
    // R6: when a clear finishes, the whole array is empty.
    p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (all_bits == '0));

endmodule

// File: tb/bloom_bin_test.sv
// Bench for bloom_bin in a small configuration (8-bit rows, 64 bits,
// three hashes, 8-bit words), sweeping every row against a bit model.
module bloom_bin_test;
    localparam int AW = 8;
    localparam int NB = 64;
    localparam int NH = 3;
    localparam int WW = 8;
    localparam int IW = 6;
    localparam int NROWS = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_start = 1'b0;
    logic          ins_valid = 1'b0;
    logic [AW-1:0] ins_row = '0;
    logic          qry_valid = 1'b0;
    logic [AW-1:0] qry_row = '0;
    logic          busy;
    logic          resp_valid;
    logic          resp_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit model [NB];

    bloom_bin #(.ADDR_W(AW), .BITS(NB), .NHASH(NH), .WORD_W(WW)) uut (
        .clk(clk), .rst_n(rst_n), .clr_start(clr_start),
        .ins_valid(ins_valid), .ins_row(ins_row),
        .qry_valid(qry_valid), .qry_row(qry_row),
        .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit)
    );

    always #2 clk = ~clk;

    // Index of hash k for row a, computed from the stated definition.
    function automatic int hidx(input int a, input int k);
        int r;
        int rot;
        int salt;
        int v;
        int acc;
        int unsigned prod;
        r    = k % AW;
        rot  = ((a << r) | (a >> (AW - r))) & (NROWS - 1);
        prod = (k + 1) * 32'h9E3779B1;
        salt = int'(prod % NROWS);
        v    = rot ^ salt;
        acc  = 0;
        while (v != 0) begin
            acc = acc ^ (v % NB);
            v   = v / NB;
        end
        return acc;
    endfunction

    function automatic bit exp_hit(input int a);
        bit h = 1'b1;
        for (int k = 0; k < NH; k++) begin
            if (!model[hidx(a, k)]) h = 1'b0;
        end
        return h;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NB; i++) model[i] = 1'b0;
    endtask

    task automatic model_insert(input int a);
        for (int k = 0; k < NH; k++) model[hidx(a, k)] = 1'b1;
    endtask

    task automatic do_insert(input int a);
        @(negedge clk);
        ins_valid = 1'b1;
        ins_row   = AW'(a);
        @(negedge clk);
        ins_valid = 1'b0;
        model_insert(a);
    endtask

    task automatic do_query(input int a, input string req);
        @(negedge clk);
        qry_valid = 1'b1;
        qry_row   = AW'(a);
        @(negedge clk);
        qry_valid = 1'b0;
        check({req, " resp_valid"}, int'(resp_valid), 1);
        check({req, " resp_hit"}, int'(resp_hit), int'(exp_hit(a)));
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < NROWS; a++) do_query(a, req);
    endtask

    // Start a clear; optionally push requests during it. Returns busy cycles.
    task automatic run_clear(input bit poke, input int poke_row, output int n);
        @(negedge clk);
        clr_start = 1'b1;
        ins_valid = poke;
        ins_row   = AW'(poke_row);
        qry_valid = poke;
        qry_row   = AW'(poke_row);
        @(negedge clk);
        clr_start = 1'b0;
        n = 0;
        while (busy && n < 100) begin
            check("R7 no response while busy", int'(resp_valid), 0);
            n++;
            clr_start = poke && (n == 3);
            @(negedge clk);
        end
        clr_start = 1'b0;
        ins_valid = 1'b0;
        qry_valid = 1'b0;
        check("R7 no response after busy", int'(resp_valid), 0);
        model_clear();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int n;
        int m;
        model_clear();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and an empty array.
        check("R1 busy after reset", int'(busy), 0);
        check("R1 resp_valid after reset", int'(resp_valid), 0);
        sweep("R1 empty");

        // R2: one row alone; exact bit positions exposed by the sweep.
        do_insert(8'h5A);
        sweep("R2 single row");

        // R3/R4: a mix of rows, then every row against the model.
        for (int i = 0; i < 9; i++) do_insert((i * 37 + 11) % NROWS);
        for (int i = 0; i < 9; i++) begin
            do_query((i * 37 + 11) % NROWS, "R3 inserted row");
            check("R3 inserted hit", int'(resp_hit), 1);
        end
        sweep("R4 mixed");

        // R5: same-cycle insert and lookup sees the old array.
        m = -1;
        for (int a = 0; a < NROWS; a++) if (m < 0 && !exp_hit(a)) m = a;
        if (m < 0) m = 0;
        @(negedge clk);
        ins_valid = 1'b1; ins_row = AW'(m);
        qry_valid = 1'b1; qry_row = AW'(m);
        @(negedge clk);
        ins_valid = 1'b0; qry_valid = 1'b0;
        check("R5 resp_valid", int'(resp_valid), 1);
        check("R5 pre-insert hit", int'(resp_hit), int'(exp_hit(m)));
        model_insert(m);
        do_query(m, "R5 after insert");

        // R6: plain clear timing and empty result.
        run_clear(1'b0, 0, n);
        check("R6 busy cycles", n, NB / WW);
        sweep("R6 after clear");

        // R7/R8: requests and a second start during a clear are dropped.
        do_insert(8'h33);
        run_clear(1'b1, 8'hC4, n);
        check("R8 busy cycles with restart", n, NB / WW);
        @(negedge clk);
        check("R8 busy stays low", int'(busy), 0);
        sweep("R7 dropped requests");

        // R9: every row inserted; all hit, and clear still works.
        for (int a = 0; a < NROWS; a++) do_insert(a);
        sweep("R9 saturated");
        check("R9 busy low when full", int'(busy), 0);
        run_clear(1'b0, 0, n);
        check("R9 clear after saturation", n, NB / WW);
        do_query(8'hC4, "R9 after clear");

        finish_run();
    end

endmodule